// File: doc/BRIEF.md
# CAN Bit Timing and Synchronisation Unit

This block turns the I/O clock into CAN time quanta and walks each nominal bit through its four segments: a one-quantum sync segment, a propagation segment, a first phase segment and a second phase segment. It gives the protocol engine a one-clock transmit-point pulse at the start of every bit. It also gives a one-clock sample pulse at the end of the first phase segment, together with the value sampled from the receive line there.

While the bus is active, the unit follows the transmitters on it. A recessive-to-dominant edge that arrives late in a bit lengthens the first phase segment. One that arrives early shortens the second phase segment. Each correction is limited to the programmed jump width, and only one correction is made per bit. Once 11 consecutive recessive bits have been sampled, the bus counts as idle. The channel then joins the bus, and the next falling edge restarts the bit timing outright (hard synchronisation).

Each timing field holds a value n and selects n+1 quanta. The information processing time is fixed at 2 quanta, so the second phase segment must be programmed to at least 2 quanta. The total bit length must lie between 8 and 25 quanta. Frame decoding, stuffing and CRC are handled elsewhere.

Top module: `can_bit_timer`

## Requirements
- R1: A quantum lasts `tq_div`+1 clocks. A bit lasts (1 + (`prop_len`+1) + (`ph1_len`+1) + (`ph2_len`+1)) quanta when no edge adjusts it. Field value n means n+1 quanta for every timing field.
- R2: `tx_point` pulses for one clock when each bit starts. `sample_point` pulses for one clock at the last clock of the first phase segment and updates `rx_bit` there. The two pulses never coincide.
- R3: When `tq_div` is 0, the first phase segment is one quantum longer than programmed, which moves the sample point one quantum later.
- R4: A falling edge seen while the quantum index q lies between 1 and the sample point lengthens the first phase segment by min(q, `jump_len`+1) quanta.
- R5: A falling edge seen after the sample point, with r quanta left in the bit, shortens the second phase segment by `jump_len`+1 quanta. If r ≤ `jump_len`+1, a new bit starts on the next clock instead.
- R6: At most one resynchronisation is made per bit. An edge seen in the sync quantum has no effect on timing.
- R7: A falling edge seen while `bus_idle` is high starts a new bit (`tx_point`) on the next clock and clears `bus_idle`.
- R8: `bus_idle` rises after 11 consecutive recessive samples and falls on a dominant sample. `bus_on` rises one clock after `bus_idle` and then stays high until `enable` goes low.
- R9: With `vote3` high, the sampled value is the majority of the line at the sample clock and at the last clock of each of the two quanta before it. With `vote3` low, it is the line at the sample clock.
- R10: After reset, and one clock after `enable` is sampled low, the outputs are held: `tx_point`, `sample_point`, `bus_idle` and `bus_on` are 0, and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | synchronous active-low reset |
| enable | input | 1 | channel enable; low holds the timing logic cleared |
| tq_div | input | 6 | quantum prescale, n means n+1 clocks |
| prop_len | input | 3 | propagation segment, n means n+1 quanta |
| ph1_len | input | 3 | first phase segment, n means n+1 quanta |
| ph2_len | input | 3 | second phase segment, n means n+1 quanta |
| jump_len | input | 2 | resynchronisation jump width, n means n+1 quanta |
| vote3 | input | 1 | three-sample majority vote |
| rx_in | input | 1 | receive line, already synchronous to clk, 1 = recessive |
| tx_point | output | 1 | start-of-bit strobe |
| sample_point | output | 1 | sample strobe |
| rx_bit | output | 1 | last sampled bit value |
| bus_idle | output | 1 | 11 or more recessive bits sampled in a row |
| bus_on | output | 1 | channel has joined the bus |

## Verification
Every strobe is registered. `tx_point` and `sample_point` therefore appear one clock after the edge at which the bit boundary or sample point is decided. An edge on `rx_in` driven at one falling clock edge acts at the next rising edge and shows its effect on the strobes at the falling edge after that. `bus_on` follows `bus_idle` by one more clock. The bench drives inputs and samples outputs on falling edges, and keeps a behavioural model updated on rising edges that it compares every cycle. Its directed probes count the falling edges between pulses and compare them with gaps worked out from the quantum arithmetic, for example 24 clocks for a plain 12-quantum bit at prescale 2, 26 after a late edge and 23 after an early edge within the jump width.

// File: rtl/can_bt_pkg.sv
// Package: shared widths and helpers for the CAN bit timing unit.
// Assumes: field value n selects n+1 units; all sums fit in quanta_t.
package can_bt_pkg;
    localparam int TQDIV_W   = 6;
    localparam int SEG_W     = 3;
    localparam int JUMP_W    = 2;
    localparam int IDLE_BITS = 11;
    localparam int HIST_N    = 2;
    localparam int MAX_Q     = 2 + 3 * (1 << SEG_W) + (1 << JUMP_W);
    localparam int Q_W       = $clog2(MAX_Q + 1);
    localparam int RUN_W     = $clog2(IDLE_BITS + 1);

    typedef logic [Q_W-1:0]   quanta_t;
    typedef logic [RUN_W-1:0] run_t;

    // majority of three line samples
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/can_bt_prescaler.sv
// Module: quantum prescaler.
// Counts clk cycles and emits tq_tick on the last clock of every quantum.
// Assumes: restart begins a fresh quantum on the following clock.
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               restart,
    input  logic [TQDIV_W-1:0] tq_div,
    output logic               tq_tick
);
    logic [TQDIV_W-1:0] cnt_r;

    assign tq_tick = en & (cnt_r == tq_div);

    // clock counter within the current quantum
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            cnt_r <= '0;
        end else if (tq_tick) begin
            cnt_r <= '0;
        end else begin
            cnt_r <= cnt_r + TQDIV_W'(1);
        end
    end
endmodule

// File: rtl/can_bt_sampler.sv
// Module: receive-line sampler and idle detector.
// Detects recessive-to-dominant edges, keeps the line values of the last
// HIST_N quanta, takes the (optionally voted) sample, and counts
// consecutive recessive samples up to IDLE_BITS.
// Assumes: rx_in is already synchronous to clk; 1 is recessive.
module can_bt_sampler
    import can_bt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rx_in,
    input  logic vote3,
    input  logic tq_tick,
    input  logic sample_hit,
    input  logic hard_sync,
    output logic fall,
    output logic idle,
    output logic rx_bit,
    output logic sample_point,
    output logic bus_on
);
    logic              rx_d;
    logic [HIST_N-1:0] hist_r;
    run_t              run_r;
    logic              sample_val;

    assign fall       = en & rx_d & ~rx_in;
    assign idle       = (run_r == run_t'(IDLE_BITS));
    assign sample_val = vote3 ? maj3(rx_in, hist_r[0], hist_r[1]) : rx_in;

    // previous line value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n || !en) rx_d <= 1'b1;
        else               rx_d <= rx_in;
    end

    // history of the line at the end of each quantum
    for (genvar gi = 0; gi < HIST_N; gi++) begin : g_hist
        always_ff @(posedge clk) begin
            if (!rst_n || !en) begin
                hist_r[gi] <= 1'b1;
            end else if (tq_tick) begin
                if (gi == 0) hist_r[gi] <= rx_in;
                else         hist_r[gi] <= hist_r[(gi == 0) ? 0 : gi - 1];
            end
        end
    end

    // sampled bit and sample strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            rx_bit       <= 1'b1;
            sample_point <= 1'b0;
        end else begin
            sample_point <= sample_hit;
            if (sample_hit) rx_bit <= sample_val;
        end
    end

    // run length of recessive samples, saturating at IDLE_BITS
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_r <= '0;
        end else if (hard_sync) begin
            run_r <= '0;
        end else if (sample_hit) begin
            if (!sample_val)  run_r <= '0;
            else if (!idle)   run_r <= run_r + run_t'(1);
        end
    end

    // sticky bus-joined flag
    always_ff @(posedge clk) begin
        if (!rst_n || !en) bus_on <= 1'b0;
        else if (idle)     bus_on <= 1'b1;
    end
endmodule

// File: rtl/can_bt_sequencer.sv
// Module: bit segment sequencer.
// Tracks the quantum index inside a bit, places the sample point and
// bit end, and applies hard and soft synchronisation.
// Assumes: segment fields hold n for n+1 quanta; a zero prescale adds
// one quantum to the first phase segment; one resync per bit.
module can_bt_sequencer
    import can_bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tq_tick,
    input  logic              fall,
    input  logic              idle,
    input  logic              div_zero,
    input  logic [SEG_W-1:0]  prop_len,
    input  logic [SEG_W-1:0]  ph1_len,
    input  logic [SEG_W-1:0]  ph2_len,
    input  logic [JUMP_W-1:0] jump_len,
    output logic              restart,
    output logic              hard_sync,
    output logic              sample_hit,
    output logic              bit_start
);
    quanta_t q_r, ext_r, cut_r;
    logic    synced_r;

    quanta_t base_q, last_nom, jump_q, remain_q, ext_new, ext_eff, cut_eff;
    quanta_t samp_q, last_q;
    logic    resync, late, early, early_restart, roll;

    // segment arithmetic and synchronisation decisions
    always_comb begin
        base_q   = quanta_t'(prop_len) + quanta_t'(ph1_len) + quanta_t'(2)
                 + quanta_t'(div_zero);
        last_nom = base_q + quanta_t'(ph2_len) + quanta_t'(1);
        jump_q   = quanta_t'(jump_len) + quanta_t'(1);
        remain_q = last_nom + quanta_t'(1) - q_r;
        ext_new  = (q_r < jump_q) ? q_r : jump_q;

        hard_sync     = fall & idle;
        resync        = fall & ~idle & ~synced_r & (q_r != '0);
        late          = resync & (q_r <= base_q);
        early         = resync & (q_r > base_q);
        early_restart = early & (remain_q <= jump_q);
        restart       = hard_sync | early_restart;

        ext_eff = late ? ext_new : ext_r;
        cut_eff = (early & ~early_restart) ? jump_q : cut_r;
        samp_q  = base_q + ext_eff;
        last_q  = last_nom + ext_eff - cut_eff;

        sample_hit = tq_tick & ~restart & (q_r == samp_q);
        roll       = tq_tick & ~restart & (q_r >= last_q);
        bit_start  = restart | roll;
    end

    // quantum index and per-bit adjustment state
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            q_r      <= '0;
            ext_r    <= '0;
            cut_r    <= '0;
            synced_r <= 1'b0;
        end else if (restart) begin
            q_r      <= '0;
            ext_r    <= '0;
            cut_r    <= '0;
            synced_r <= 1'b1;
        end else if (roll) begin
            q_r      <= '0;
            ext_r    <= '0;
            cut_r    <= '0;
            synced_r <= 1'b0;
        end else begin
            ext_r    <= ext_eff;
            cut_r    <= cut_eff;
            synced_r <= synced_r | resync;
            if (tq_tick) q_r <= q_r + quanta_t'(1);
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
// Module: CAN bit timing and synchronisation top.
// Joins prescaler, sequencer and sampler; registers the start-of-bit
// strobe. Assumes configuration changes only while enable is low.
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [TQDIV_W-1:0] tq_div,
    input  logic [SEG_W-1:0]   prop_len,
    input  logic [SEG_W-1:0]   ph1_len,
    input  logic [SEG_W-1:0]   ph2_len,
    input  logic [JUMP_W-1:0]  jump_len,
    input  logic               vote3,
    input  logic               rx_in,
    output logic               tx_point,
    output logic               sample_point,
    output logic               rx_bit,
    output logic               bus_idle,
    output logic               bus_on
);
    logic tq_tick, restart, hard_sync, sample_hit, bit_start, fall, idle;

    can_bt_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (enable),
        .restart (restart),
        .tq_div  (tq_div),
        .tq_tick (tq_tick)
    );

    can_bt_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (enable),
        .tq_tick    (tq_tick),
        .fall       (fall),
        .idle       (idle),
        .div_zero   (tq_div == '0),
        .prop_len   (prop_len),
        .ph1_len    (ph1_len),
        .ph2_len    (ph2_len),
        .jump_len   (jump_len),
        .restart    (restart),
        .hard_sync  (hard_sync),
        .sample_hit (sample_hit),
        .bit_start  (bit_start)
    );

    can_bt_sampler u_smp (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (enable),
        .rx_in        (rx_in),
        .vote3        (vote3),
        .tq_tick      (tq_tick),
        .sample_hit   (sample_hit),
        .hard_sync    (hard_sync),
        .fall         (fall),
        .idle         (idle),
        .rx_bit       (rx_bit),
        .sample_point (sample_point),
        .bus_on       (bus_on)
    );

    assign bus_idle = idle;

    // start-of-bit strobe register
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) tx_point <= 1'b0;
        else                   tx_point <= bit_start;
    end
endmodule

// File: rtl/can_bit_timer_chk.sv
// Module: property checker for can_bit_timer, bound to every instance.
module can_bit_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic tx_point,
    input logic sample_point,
    input logic rx_bit,
    input logic bus_idle,
    input logic bus_on
);
    // R2: sample and start-of-bit strobes are never together
    p_strobes_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_point && sample_point));

    // R2: the sample strobe lasts one clock
    p_sample_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_point |=> !sample_point);

    // R7, R8: idle ends only by hard sync, a dominant sample or disable
    p_idle_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_idle) |-> (tx_point || (sample_point && !rx_bit) || !$past(enable)));

    // R8: joining the bus follows an idle bus
    p_join_after_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_on) |-> $past(bus_idle));

    // R8: joined state is kept while enabled
    p_join_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_on && enable) |=> bus_on);

    // R10: disabling quiets every output
    p_disable_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tx_point && !sample_point && !bus_idle && !bus_on && rx_bit));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .tx_point     (tx_point),
    .sample_point (sample_point),
    .rx_bit       (rx_bit),
    .bus_idle     (bus_idle),
    .bus_on       (bus_on)
);

// File: tb/can_bit_timer_tb_top.sv
// Bench: behavioural reference compared every clock plus directed probes.
module can_bit_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [5:0] tq_div = 6'd1;
    logic [2:0] prop_len = 3'd2;
    logic [2:0] ph1_len = 3'd3;
    logic [2:0] ph2_len = 3'd3;
    logic [1:0] jump_len = 2'd0;
    logic       vote3 = 1'b0;
    logic       rx_in = 1'b1;
    logic       tx_point, sample_point, rx_bit, bus_idle, bus_on;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_bit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tq_div(tq_div),
        .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len),
        .jump_len(jump_len), .vote3(vote3), .rx_in(rx_in),
        .tx_point(tx_point), .sample_point(sample_point), .rx_bit(rx_bit),
        .bus_idle(bus_idle), .bus_on(bus_on)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_pc, m_q, m_ext, m_cut, m_run;
    bit m_syn, m_rxd, m_h0, m_h1, m_tx, m_sp, m_rxb, m_bon;

    task automatic model_clear();
        m_pc = 0; m_q = 0; m_ext = 0; m_cut = 0; m_run = 0;
        m_syn = 0; m_rxd = 1; m_h0 = 1; m_h1 = 1;
        m_tx = 0; m_sp = 0; m_rxb = 1; m_bon = 0;
    endtask

    always @(posedge clk) begin
        int base, jmp, rem, ext_n, cut_n, votes;
        bit tick, fall, idle, hard, rs, early_go, restart, hit, roll, val;
        if (!rst_n || !enable) begin
            model_clear();
        end else begin
            base  = int'(prop_len) + int'(ph1_len) + 2 + ((tq_div == 0) ? 1 : 0);
            jmp   = int'(jump_len) + 1;
            tick  = (m_pc == int'(tq_div));
            fall  = m_rxd && !rx_in;
            idle  = (m_run == 11);
            hard  = fall && idle;
            rs    = fall && !idle && !m_syn && (m_q != 0);
            ext_n = m_ext;
            cut_n = m_cut;
            early_go = 0;
            if (rs && m_q <= base) ext_n = (m_q < jmp) ? m_q : jmp;
            if (rs && m_q > base) begin
                rem = base + int'(ph2_len) + 2 - m_q;
                if (rem <= jmp) early_go = 1;
                else            cut_n = jmp;
            end
            restart = hard || early_go;
            hit  = tick && !restart && (m_q == base + ext_n);
            roll = tick && !restart && (m_q >= base + int'(ph2_len) + 1 + ext_n - cut_n);
            votes = int'(rx_in) + int'(m_h0) + int'(m_h1);
            val  = vote3 ? (votes >= 2) : rx_in;
            m_tx = restart || roll;
            m_sp = hit;
            if (hit) m_rxb = val;
            m_bon = m_bon || idle;
            if (hard) m_run = 0;
            else if (hit) m_run = val ? ((m_run < 11) ? m_run + 1 : 11) : 0;
            if (tick) begin m_h1 = m_h0; m_h0 = rx_in; end
            m_rxd = rx_in;
            if (restart) begin
                m_pc = 0; m_q = 0; m_ext = 0; m_cut = 0; m_syn = 1;
            end else if (roll) begin
                m_pc = 0; m_q = 0; m_ext = 0; m_cut = 0; m_syn = 0;
            end else begin
                m_ext = ext_n; m_cut = cut_n; m_syn = m_syn || rs;
                if (tick) begin m_pc = 0; m_q = m_q + 1; end
                else      m_pc = m_pc + 1;
            end
        end
    end

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tx_point == m_tx, "R2,R5,R7 model tx_point", tx_point, m_tx);
            check(sample_point == m_sp, "R2,R4 model sample_point", sample_point, m_sp);
            check(rx_bit == m_rxb, "R9 model rx_bit", rx_bit, m_rxb);
            check(bus_idle == (m_run == 11), "R8 model bus_idle", bus_idle, int'(m_run == 11));
            check(bus_on == m_bon, "R8 model bus_on", bus_on, m_bon);
        end
    end

    // ---------------- directed probes ----------------
    // Wait for a bit start, optionally pull rx low at two offsets, and
    // return the falling-edge count to the next bit start.
    task automatic bit_probe(input int drop1, input int drop2, input int hold, output int gap);
        int last;
        gap = -1;
        while (tx_point !== 1'b1) @(negedge clk);
        last = (drop2 > drop1 ? drop2 : drop1) + hold;
        for (int n = 1; n < 200; n++) begin
            @(negedge clk);
            if (gap < 0 && tx_point) gap = n;
            if (n == drop1 || n == drop2) rx_in = 1'b0;
            else if (n == drop1 + 1 && drop2 > drop1 + 1) rx_in = 1'b1;
            if (n == last) rx_in = 1'b1;
            if (gap >= 0 && n >= last) break;
        end
        rx_in = 1'b1;
    endtask

    task automatic sample_offset(output int off);
        off = -1;
        while (tx_point !== 1'b1) @(negedge clk);
        for (int n = 1; n < 200; n++) begin
            @(negedge clk);
            if (sample_point) begin off = n; break; end
        end
    endtask

    task automatic vote_probe(input bit exp, input string req);
        while (tx_point !== 1'b1) @(negedge clk);
        rx_in = 1'b0;
        for (int n = 1; n <= 26; n++) begin
            @(negedge clk);
            if (n == 15) rx_in = 1'b1;
            if (n == 16) begin
                check(sample_point == 1'b1, req, sample_point, 1);
                check(rx_bit == exp, req, rx_bit, exp);
                rx_in = 1'b0;
            end
        end
        rx_in = 1'b1;
    endtask

    initial begin
        int g;
        repeat (3) @(negedge clk);
        check(tx_point == 0 && sample_point == 0, "R10 reset strobes", tx_point + sample_point, 0);
        check(rx_bit == 1 && bus_idle == 0 && bus_on == 0, "R10 reset state", {rx_bit, bus_idle, bus_on}, 3'b100);
        rst_n = 1'b1;

        // 12-quantum bit, two clocks per quantum
        enable = 1'b1;
        repeat (255) @(negedge clk);
        check(bus_idle == 0, "R8 idle not before 11 bits", bus_idle, 0);
        @(negedge clk);
        check(bus_idle == 1 && bus_on == 0, "R8 idle after 11 bits", {bus_idle, bus_on}, 2'b10);
        @(negedge clk);
        check(bus_on == 1, "R8 bus_on one clock later", bus_on, 1);

        repeat (5) @(negedge clk);
        rx_in = 1'b0;
        @(negedge clk);
        check(tx_point == 1 && bus_idle == 0, "R7 hard sync", {tx_point, bus_idle}, 2'b10);
        for (int n = 1; n <= 16; n++) begin
            @(negedge clk);
            if (n == 16) check(sample_point == 1, "R7 sample after hard sync", sample_point, 1);
            if (n == 18) rx_in = 1'b1;
        end
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        check(bus_on == 1, "R8 bus_on sticky", bus_on, 1);

        bit_probe(0, 0, 0, g);   check(g == 24, "R1 plain bit length", g, 24);
        bit_probe(4, 0, 14, g);  check(g == 26, "R4 late edge lengthens", g, 26);
        bit_probe(0, 0, 0, g);   check(g == 24, "R1 plain after late", g, 24);
        bit_probe(22, 0, 20, g); check(g == 23, "R5 early edge restarts", g, 23);
        bit_probe(0, 0, 0, g);
        bit_probe(0, 0, 0, g);
        bit_probe(20, 0, 20, g); check(g == 22, "R5 early edge shortens", g, 22);
        bit_probe(0, 0, 0, g);
        bit_probe(0, 0, 0, g);
        bit_probe(4, 8, 14, g);  check(g == 26, "R6 one resync per bit", g, 26);
        bit_probe(0, 0, 0, g);
        bit_probe(1, 0, 30, g);  check(g == 24, "R6 edge in sync quantum ignored", g, 24);
        bit_probe(0, 0, 0, g);

        // disable quiets outputs
        enable = 1'b0;
        @(negedge clk);
        check(!tx_point && !sample_point && !bus_idle && !bus_on && rx_bit, "R10 disable",
              {tx_point, sample_point, bus_idle, bus_on, rx_bit}, 5'b00001);

        // wider jump: late error 3 limited to 2
        jump_len = 2'd1;
        enable = 1'b1;
        bit_probe(0, 0, 0, g);
        bit_probe(6, 0, 14, g);  check(g == 28, "R4 jump limit", g, 28);
        sample_offset(g);        check(g == 16, "R2 sample offset", g, 16);

        // zero prescale: 10-quantum bit, sample at quantum 8
        enable = 1'b0;
        @(negedge clk);
        tq_div = 6'd0; prop_len = 3'd1; ph1_len = 3'd3; ph2_len = 3'd1; jump_len = 2'd0;
        enable = 1'b1;
        bit_probe(0, 0, 0, g);   check(g == 10, "R1 zero prescale bit length", g, 10);
        sample_offset(g);        check(g == 8, "R3 phase one lengthened", g, 8);

        // three-sample vote versus single sample
        enable = 1'b0;
        @(negedge clk);
        tq_div = 6'd1; prop_len = 3'd2; ph1_len = 3'd3; ph2_len = 3'd3;
        vote3 = 1'b0;
        enable = 1'b1;
        bit_probe(0, 0, 0, g);
        vote_probe(1'b1, "R9 single sample");
        enable = 1'b0;
        @(negedge clk);
        vote3 = 1'b1;
        enable = 1'b1;
        bit_probe(0, 0, 0, g);
        vote_probe(1'b0, "R9 majority vote");

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 100000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule